// File: doc/BRIEF.md
# Asynchronous Static RAM Controller with Byte Lanes

This block connects on-chip logic to an external asynchronous static RAM of 32K words by 16 bits. A host issues one request at a time: a 15-bit word address, a direction bit, 16 bits of write data and a 2-bit byte mask. The controller latches the request, runs the pin sequence on the memory side, and asserts ready on the last cycle of the access. Reads return their data one cycle later, together with a single-cycle valid pulse.

Every pin toward the memory comes from a flop. Each phase of an access lasts a whole number of clock cycles. These counts come from the clock period and the memory's nanosecond limits, always rounding up. A write has three phases. In the setup phase the chip is selected and the bus is driven. In the pulse phase write enable is low. In the hold phase write enable is back high, while address and data stay put. A read holds chip select and output enable low for the access count. It then frees the bus for one cycle before anything else may drive it.

The data bus is split into an output, an output-enable for the pad tristate, and an input. The memory's strobes are active low. Lane 0 is data bits 7:0, gated by the lower strobe and mask bit 0. Lane 1 is bits 15:8, gated by the upper strobe and mask bit 1.

Top module: `sram_async_ctrl`

## Requirements
- R1: While rst_ni is low, chip, write and output enables and both byte strobes are high, the pad enable is low, and req_ready_o and rsp_valid_o are low.
- R2: A write with a nonzero mask runs three phases. Setup has chip select low and write enable high. The pulse phase has write enable low. The hold phase has write enable high and chip select still low. Output enable stays high the whole time, and req_ready_o is high only in the last hold cycle, so ready comes SETUP+PULSE+HOLD cycles after the accepting edge.
- R3: Phase lengths with Tclk as the clock period and every division rounded up. PULSE = max(1, Twp/Tclk, Tds/Tclk). SETUP = max(1, Taw/Tclk − PULSE). HOLD = max(1, Tah/Tclk, Twc/Tclk − SETUP − PULSE). ACCESS = Taa/Tclk + RD_MARGIN_CYC.
- R4: While chip select is low, the address pins hold the request address unchanged. While the pad enable is high, the data pins hold the write data unchanged.
- R5: During an access a strobe is low only for the lanes whose mask bit is set (bit 0 for the lower strobe, bit 1 for the upper), so a write changes only those lanes.
- R6: A read holds chip select and output enable low with write enable high for ACCESS cycles. req_ready_o is high in the last of these cycles. The bus is sampled at the end of that cycle, and rsp_valid_o is high for exactly the next cycle with the data on rsp_rdata_o.
- R7: In read data, lanes whose mask bit is clear return zero, whatever the bus carries.
- R8: The pad enable is never high while output enable is low. It is also never high in the cycle right after a cycle with output enable low.
- R9: Chip select stays high whenever no access is in progress.
- R10: A request with mask 00 never lowers chip select. Its ready comes one cycle after acceptance. As a read it also yields an rsp_valid_o pulse with zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request present |
| req_ready_o | output | 1 | Request completes at this edge |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 15 | Word address |
| req_wdata_i | input | 16 | Write data |
| req_be_i | input | 2 | Lane mask, bit 0 = bits 7:0 |
| rsp_valid_o | output | 1 | Read data valid pulse |
| rsp_rdata_o | output | 16 | Read data, masked by lane |
| mem_addr_o | output | 15 | Memory address pins |
| mem_ce_no | output | 1 | Chip select, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_ub_no | output | 1 | Upper lane strobe, active low |
| mem_lb_no | output | 1 | Lower lane strobe, active low |
| mem_dq_o | output | 16 | Data toward the memory |
| mem_dq_oe_o | output | 1 | Pad tristate enable for mem_dq_o |
| mem_dq_i | input | 16 | Data from the memory |

## Verification
With the default timing, the bench expects ready 4 cycles after a write is accepted (1 setup, 2 pulse, 1 hold), 3 cycles after a read, and 1 cycle after a zero-mask request. It expects read data and its valid pulse exactly one cycle after ready, and no pulse in the cycle after that. The bench counts cycles from the accepting edge and samples every result at the falling edge of the cycle in which it is due. A pin monitor in the bench measures phase lengths and bus ownership on every falling edge, and its results are read only after the access has closed.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WSETUP = 3'd1,
    ST_WPULSE = 3'd2,
    ST_WHOLD  = 3'd3,
    ST_RACC   = 3'd4,
    ST_TURN   = 3'd5,
    ST_SKIP   = 3'd6
  } ctrl_state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_cnt.sv
module sram_phase_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 2,
  parameter int HOLD_CYC  = 1,
  parameter int ACC_CYC   = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic req_we_i,
  input  logic req_be_zero_i,
  input  logic lat_we_i,
  output logic accept_o,
  output logic req_ready_o,
  output logic capture_o,
  output logic rsp_valid_o,
  output logic strobe_en_d_o,
  output logic mem_ce_no,
  output logic mem_we_no,
  output logic mem_oe_no,
  output logic dq_oe_o
);

  localparam int MAX_LEN = max2(max2(SETUP_CYC, PULSE_CYC), max2(HOLD_CYC, ACC_CYC));
  localparam int CNT_W   = max2(1, $clog2(MAX_LEN + 1));

  ctrl_state_e      state_q, state_d;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             cnt_zero;

  sram_phase_cnt #(.CNT_W(CNT_W)) u_phase_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .zero_o     (cnt_zero)
  );

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          if (req_be_zero_i) begin
            state_d = ST_SKIP;
          end else if (req_we_i) begin
            state_d  = ST_WSETUP;
            load     = 1'b1;
            load_val = CNT_W'(SETUP_CYC - 1);
          end else begin
            state_d  = ST_RACC;
            load     = 1'b1;
            load_val = CNT_W'(ACC_CYC - 1);
          end
        end
      end
      ST_WSETUP: if (cnt_zero) begin
        state_d  = ST_WPULSE;
        load     = 1'b1;
        load_val = CNT_W'(PULSE_CYC - 1);
      end
      ST_WPULSE: if (cnt_zero) begin
        state_d  = ST_WHOLD;
        load     = 1'b1;
        load_val = CNT_W'(HOLD_CYC - 1);
      end
      ST_WHOLD: if (cnt_zero) state_d = ST_IDLE;
      ST_RACC:  if (cnt_zero) state_d = ST_TURN;
      ST_TURN:  state_d = ST_IDLE;
      ST_SKIP:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign accept_o    = (state_q == ST_IDLE) && req_valid_i;
  assign req_ready_o = ((state_q == ST_WHOLD || state_q == ST_RACC) && cnt_zero) ||
                       (state_q == ST_SKIP);
  assign capture_o   = ((state_q == ST_RACC) && cnt_zero) ||
                       ((state_q == ST_SKIP) && !lat_we_i);

  // Pin controls decoded from the next state, so every pin leaves a flop.
  logic wr_d, rd_d;
  assign wr_d          = (state_d == ST_WSETUP) || (state_d == ST_WPULSE) || (state_d == ST_WHOLD);
  assign rd_d          = (state_d == ST_RACC);
  assign strobe_en_d_o = wr_d || rd_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      mem_ce_no   <= 1'b1;
      mem_we_no   <= 1'b1;
      mem_oe_no   <= 1'b1;
      dq_oe_o     <= 1'b0;
      rsp_valid_o <= 1'b0;
    end else begin
      state_q     <= state_d;
      mem_ce_no   <= !(wr_d || rd_d);
      mem_we_no   <= (state_d != ST_WPULSE);
      mem_oe_no   <= !rd_d;
      dq_oe_o     <= wr_d;
      rsp_valid_o <= capture_o;
    end
  end

  assert_pulse_after_setup_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WPULSE && $past(state_q) != ST_WPULSE) |-> $past(state_q) == ST_WSETUP);

  assert_turn_after_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TURN) |-> $past(state_q) == ST_RACC);

  assert_standby_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE || state_q == ST_SKIP || state_q == ST_TURN) |-> mem_ce_no);

endmodule

// File: rtl/sram_lane_io.sv
module sram_lane_io #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    strobe_en_i,
  input  logic [LANES-1:0]        be_nxt_i,
  input  logic [LANES-1:0]        be_q_i,
  input  logic                    capture_i,
  input  logic [LANES*LANE_W-1:0] dq_i,
  output logic [LANES-1:0]        strobe_no,
  output logic [LANES*LANE_W-1:0] rdata_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        strobe_no[g]                 <= 1'b1;
        rdata_o[g*LANE_W +: LANE_W]  <= '0;
      end else begin
        strobe_no[g] <= !(strobe_en_i && be_nxt_i[g]);
        // A lane left unstrobed floats on the bus; return zero for it.
        if (capture_i)
          rdata_o[g*LANE_W +: LANE_W] <= be_q_i[g] ? dq_i[g*LANE_W +: LANE_W] : '0;
      end
    end
  end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 15,
  parameter int DATA_W        = 16,
  parameter int LANE_W        = 8,
  parameter int CLK_PERIOD_PS = 5000,
  parameter int T_WP_PS       = 7000,
  parameter int T_DS_PS       = 5000,
  parameter int T_AW_PS       = 9000,
  parameter int T_AH_PS       = 1000,
  parameter int T_WC_PS       = 10000,
  parameter int T_AA_PS       = 10000,
  parameter int RD_MARGIN_CYC = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [1:0]        req_be_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_no,
  output logic              mem_we_no,
  output logic              mem_oe_no,
  output logic              mem_ub_no,
  output logic              mem_lb_no,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int LANES     = DATA_W / LANE_W;
  localparam int PULSE_CYC = max2(1, max2(ceil_div(T_WP_PS, CLK_PERIOD_PS),
                                          ceil_div(T_DS_PS, CLK_PERIOD_PS)));
  localparam int SETUP_CYC = max2(1, ceil_div(T_AW_PS, CLK_PERIOD_PS) - PULSE_CYC);
  localparam int HOLD_CYC  = max2(max2(1, ceil_div(T_AH_PS, CLK_PERIOD_PS)),
                                  ceil_div(T_WC_PS, CLK_PERIOD_PS) - SETUP_CYC - PULSE_CYC);
  localparam int ACC_CYC   = max2(1, ceil_div(T_AA_PS, CLK_PERIOD_PS) + RD_MARGIN_CYC);

  logic              accept, capture, strobe_en_d;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [1:0]        be_q, be_nxt;
  logic [LANES-1:0]  strobe_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (accept) begin
      we_q    <= req_we_i;
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
      be_q    <= req_be_i;
    end
  end

  assign be_nxt = accept ? req_be_i : be_q;

  sram_ctrl_fsm #(
    .SETUP_CYC (SETUP_CYC),
    .PULSE_CYC (PULSE_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .ACC_CYC   (ACC_CYC)
  ) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .req_we_i      (req_we_i),
    .req_be_zero_i (req_be_i == 2'b00),
    .lat_we_i      (we_q),
    .accept_o      (accept),
    .req_ready_o   (req_ready_o),
    .capture_o     (capture),
    .rsp_valid_o   (rsp_valid_o),
    .strobe_en_d_o (strobe_en_d),
    .mem_ce_no     (mem_ce_no),
    .mem_we_no     (mem_we_no),
    .mem_oe_no     (mem_oe_no),
    .dq_oe_o       (mem_dq_oe_o)
  );

  sram_lane_io #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .strobe_en_i (strobe_en_d),
    .be_nxt_i    (be_nxt[LANES-1:0]),
    .be_q_i      (be_q[LANES-1:0]),
    .capture_i   (capture),
    .dq_i        (mem_dq_i),
    .strobe_no   (strobe_n),
    .rdata_o     (rsp_rdata_o)
  );

  assign mem_lb_no  = strobe_n[0];
  assign mem_ub_no  = strobe_n[LANES-1];
  assign mem_addr_o = addr_q;
  assign mem_dq_o   = wdata_q;

  assert_we_inside_ce_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> !mem_ce_no);

  assert_oe_off_in_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> mem_we_no);

  assert_addr_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce_no && $past(!mem_ce_no)) |-> $stable(mem_addr_o));

  assert_wdata_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_dq_oe_o && $past(mem_dq_oe_o)) |-> $stable(mem_dq_o));

  assert_strobe_inside_ce_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ub_no || !mem_lb_no) |-> !mem_ce_no);

  assert_rsp_after_ready_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(req_ready_o));

  assert_rsp_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  assert_no_bus_fight_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_no);

  assert_turnaround_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!mem_oe_no) |-> !mem_dq_oe_o);

endmodule

// File: tb/sram_async_ctrl_tb_top.sv
module sram_async_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_PS     = 5000;
  localparam int NVEC       = 14;

  function automatic int cdiv(input int n, input int d);
    return (n + d - 1) / d;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Expected phase lengths per R3 (Twp 7, Tds 5, Taw 9, Tah 1, Twc 10, Taa 10 ns, margin 1).
  localparam int P_EXP = mx(1, mx(cdiv(7000, CLK_PS), cdiv(5000, CLK_PS)));
  localparam int S_EXP = mx(1, cdiv(9000, CLK_PS) - P_EXP);
  localparam int H_EXP = mx(mx(1, cdiv(1000, CLK_PS)), cdiv(10000, CLK_PS) - S_EXP - P_EXP);
  localparam int A_EXP = cdiv(10000, CLK_PS) + 1;

  // {we, addr[14:0], wdata[15:0], be[1:0], expected read data[15:0]}
  localparam logic [49:0] VEC [NVEC] = '{
    {1'b1, 15'h0012, 16'hA55A, 2'b11, 16'h0000},
    {1'b1, 15'h7F34, 16'h1234, 2'b11, 16'h0000},
    {1'b1, 15'h0056, 16'hFFFF, 2'b11, 16'h0000},
    {1'b1, 15'h0056, 16'h0000, 2'b01, 16'h0000},
    {1'b1, 15'h0012, 16'hBEEF, 2'b10, 16'h0000},
    {1'b0, 15'h0012, 16'h0000, 2'b11, 16'hBE5A},
    {1'b0, 15'h7F34, 16'h0000, 2'b11, 16'h1234},
    {1'b0, 15'h0056, 16'h0000, 2'b11, 16'hFF00},
    {1'b0, 15'h0056, 16'h0000, 2'b01, 16'h0000},
    {1'b0, 15'h0012, 16'h0000, 2'b10, 16'hBE00},
    {1'b1, 15'h0077, 16'h1111, 2'b11, 16'h0000},
    {1'b1, 15'h0077, 16'hC3C3, 2'b00, 16'h0000},
    {1'b0, 15'h0077, 16'h0000, 2'b11, 16'h1111},
    {1'b0, 15'h0077, 16'h0000, 2'b00, 16'h0000}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_we_i = 1'b0;
  logic [14:0] req_addr_i = '0;
  logic [15:0] req_wdata_i = '0;
  logic [1:0]  req_be_i = '0;
  logic        req_ready_o, rsp_valid_o;
  logic [15:0] rsp_rdata_o;
  logic [14:0] mem_addr_o;
  logic        mem_ce_no, mem_we_no, mem_oe_no, mem_ub_no, mem_lb_no;
  logic [15:0] mem_dq_o, mem_dq_i;
  logic        mem_dq_oe_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sram_async_ctrl #(.CLK_PERIOD_PS(CLK_PS)) dut_i (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_we_i, .req_addr_i,
    .req_wdata_i, .req_be_i, .rsp_valid_o, .rsp_rdata_o, .mem_addr_o,
    .mem_ce_no, .mem_we_no, .mem_oe_no, .mem_ub_no, .mem_lb_no,
    .mem_dq_o, .mem_dq_oe_o, .mem_dq_i
  );

  // Memory model, indexed by the low address byte.
  logic [15:0] mem_arr [256];
  initial for (int i = 0; i < 256; i++) mem_arr[i] = '0;

  always_comb begin
    mem_dq_i = 16'h5A5A;  // lanes nobody drives read as junk
    if (!mem_ce_no && !mem_oe_no && mem_we_no) begin
      if (!mem_lb_no) mem_dq_i[7:0]  = mem_arr[mem_addr_o[7:0]][7:0];
      if (!mem_ub_no) mem_dq_i[15:8] = mem_arr[mem_addr_o[7:0]][15:8];
    end
  end

  // Pin monitor
  int          access_cnt = 0, fight_cnt = 0, turn_cnt = 0, addr_viol = 0, dq_viol = 0;
  int          ph_setup = 0, ph_pulse = 0, ph_hold = 0, ph_acc = 0;
  int          last_setup = 0, last_pulse = 0, last_hold = 0, last_acc = 0;
  logic [14:0] addr_first = '0, last_addr = '0;
  logic [15:0] dq_first = '0;
  logic        prev_ce_n = 1'b1, prev_oe_low = 1'b0, prev_we_low = 1'b0;

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (mem_dq_oe_o && !mem_oe_no) fight_cnt++;
      if (prev_oe_low && mem_dq_oe_o) turn_cnt++;
      if (!mem_ce_no) begin
        if (prev_ce_n) begin
          access_cnt++;
          ph_setup = 0; ph_pulse = 0; ph_hold = 0; ph_acc = 0;
          addr_first = mem_addr_o;
          dq_first   = mem_dq_o;
        end else begin
          if (mem_addr_o != addr_first) addr_viol++;
          if (mem_dq_oe_o && mem_dq_o != dq_first) dq_viol++;
        end
        if (!mem_oe_no) ph_acc++;
        if (!mem_we_no) ph_pulse++;
        else if (ph_pulse == 0 && mem_oe_no) ph_setup++;
        else if (ph_pulse > 0) ph_hold++;
      end else if (!prev_ce_n) begin
        last_setup = ph_setup; last_pulse = ph_pulse;
        last_hold  = ph_hold;  last_acc   = ph_acc;
        last_addr  = addr_first;
      end
      if (prev_we_low && mem_we_no && !mem_ce_no) begin
        if (!mem_lb_no) mem_arr[mem_addr_o[7:0]][7:0]  = mem_dq_o[7:0];
        if (!mem_ub_no) mem_arr[mem_addr_o[7:0]][15:8] = mem_dq_o[15:8];
      end
      prev_ce_n   = mem_ce_no;
      prev_oe_low = !mem_oe_no;
      prev_we_low = !mem_we_no;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // Called at a falling edge; returns shortly after a falling edge.
  task automatic run_req(input logic we, input logic [14:0] a, input logic [15:0] d,
                         input logic [1:0] be, output int lat, output logic [15:0] rd,
                         output logic rsp_seen, output logic rsp_extra);
    lat = 0; rsp_seen = 1'b0; rsp_extra = 1'b0;
    req_we_i = we; req_addr_i = a; req_wdata_i = d; req_be_i = be; req_valid_i = 1'b1;
    do begin
      @(negedge clk_i);
      lat++;
    end while (!req_ready_o && lat < 64);
    if (rsp_valid_o) rsp_extra = 1'b1;
    @(posedge clk_i);
    #1 req_valid_i = 1'b0;
    @(negedge clk_i);
    rsp_seen = rsp_valid_o;
    rd       = rsp_rdata_o;
    @(negedge clk_i);
    if (rsp_valid_o) rsp_extra = 1'b1;
    #1;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL R2 watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    int          lat, acc_before;
    logic [15:0] rd;
    logic        seen, extra;

    repeat (3) @(negedge clk_i);
    // R1: reset values
    chk(mem_ce_no && mem_we_no && mem_oe_no && mem_ub_no && mem_lb_no, "R1 strobes",
        {mem_ce_no, mem_we_no, mem_oe_no, mem_ub_no, mem_lb_no}, 5'h1F);
    chk(!mem_dq_oe_o && !req_ready_o && !rsp_valid_o, "R1 outputs",
        {mem_dq_oe_o, req_ready_o, rsp_valid_o}, 3'b000);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(mem_ce_no, "R9 idle after reset", mem_ce_no, 1'b1);

    for (int i = 0; i < NVEC; i++) begin
      logic        v_we   = VEC[i][49];
      logic [14:0] v_addr = VEC[i][48:34];
      logic [15:0] v_data = VEC[i][33:18];
      logic [1:0]  v_be   = VEC[i][17:16];
      logic [15:0] v_exp  = VEC[i][15:0];
      acc_before = access_cnt;
      run_req(v_we, v_addr, v_data, v_be, lat, rd, seen, extra);
      if (v_be == 2'b00) begin
        chk(lat == 1, "R10 zero-mask latency", lat, 1);
        chk(access_cnt == acc_before, "R10 no access", access_cnt, acc_before);
        if (!v_we) begin
          chk(seen && rd == 16'h0000, "R10 zero-mask read data", {seen, rd}, 17'h10000);
        end
      end else if (v_we) begin
        chk(lat == S_EXP + P_EXP + H_EXP, "R2 write latency", lat, S_EXP + P_EXP + H_EXP);
        chk(last_setup == S_EXP, "R3 setup cycles", last_setup, S_EXP);
        chk(last_pulse == P_EXP, "R3 pulse cycles", last_pulse, P_EXP);
        chk(last_hold == H_EXP, "R3 hold cycles", last_hold, H_EXP);
        chk(last_acc == 0, "R2 oe high in write", last_acc, 0);
        chk(last_addr == v_addr, "R4 write address", last_addr, v_addr);
        chk(!seen && !extra, "R2 no response on write", {seen, extra}, 2'b00);
      end else begin
        chk(lat == A_EXP, "R6 read latency", lat, A_EXP);
        chk(last_acc == A_EXP, "R3 access cycles", last_acc, A_EXP);
        chk(last_addr == v_addr, "R4 read address", last_addr, v_addr);
        chk(seen && !extra, "R6 single valid pulse", {seen, extra}, 2'b10);
        chk(rd == v_exp, (v_be == 2'b11) ? "R5 read data" : "R7 masked lanes", rd, v_exp);
      end
    end

    // R9: standby while idle
    for (int k = 0; k < 5; k++) begin
      @(negedge clk_i);
      chk(mem_ce_no && mem_ub_no && mem_lb_no, "R9 standby",
          {mem_ce_no, mem_ub_no, mem_lb_no}, 3'b111);
    end

    chk(fight_cnt == 0, "R8 bus fight", fight_cnt, 0);
    chk(turn_cnt == 0, "R8 turnaround", turn_cnt, 0);
    chk(addr_viol == 0, "R4 address stable", addr_viol, 0);
    chk(dq_viol == 0, "R4 data stable", dq_viol, 0);

    finish_run();
  end

endmodule